// File: doc/BRIEF.md
# I2C Serial Memory Target Engine

This block is the bus-facing engine of a byte-wide serial memory that answers as a target on a two-wire I2C bus. A fast system clock oversamples the clock and data lines. The engine finds START, repeated START and STOP conditions and shifts bytes in and out most significant bit first. It acknowledges by pulling the data line low through an open-drain enable. The memory behind it is a parameterised register array, and the top of the array is selected by two address bytes.

Writes are not applied byte by byte. Data bytes collect in a page latch that holds one 64-byte page, and the latch is copied into the array when the transaction closes with STOP. That copy starts an internal write cycle, whose length is a parameter counted in system clocks. During the cycle the device ignores its own select code, so a controller can poll until the cycle ends. A write-control input blocks data bytes while it is high. Reads can use the current address counter, a random address loaded by a dummy write, or a sequential stream.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A select byte whose upper seven bits differ from SEL_CODE (default 7'b1010000) gets no ACK, and the rest of that transaction is ignored. Bit 0 of the select byte is RW, where 0 means write and 1 means read.
- R2: A byte write is a select with RW=0, then the address high byte, the address low byte and one data byte. Each of these bytes is acknowledged. The byte becomes readable after the STOP that closes the transaction. Address bits above MEM_AW are ignored.
- R3: While wcIn is high, the select byte and both address bytes are acknowledged, data bytes are not, the array is unchanged, and no write cycle starts.
- R4: Latched data reaches the array only at STOP. A repeated START after data bytes discards them and starts no write cycle.
- R5: For WRITE_CYCLES clocks after a committing STOP, every select byte, whether RW=0 or RW=1, gets no ACK. Once the cycle ends, a select byte is acknowledged again.
- R6: A page write may carry 1 to 64 data bytes. The low six address bits wrap inside the page, so bytes past offset 63 land at the start of the same page.
- R7: A random read is a dummy write of the select byte and both address bytes, then a repeated START and a select with RW=1. It returns the byte at the loaded address.
- R8: A current-address read, which is a select with RW=1 straight after START, returns the byte that follows the last byte read.
- R9: A sequential read moves to the next address after each byte the controller ACKs, wraps from the top of the array to address 0, and ends on a controller NACK. The data line is released after the STOP that follows.
- R10: After reset the data line is released and every array byte reads as 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| wcIn | input | 1 | Write control; high blocks data bytes |
| sdaDriveLow | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The memory function is tested with single-byte writes, an 8-byte page write that starts four bytes before the page end, a 64-byte sequential read over a whole page, and a 4-byte read that crosses the top of the array. These patterns separate a correct in-page wrap from a carry into the next page, and a correct array wrap from a stall at the top address. Polling straight after a commit, and again after the cycle has ended, separates a real busy window from a missing one. A write with the write-control input high, and a write cut off by a repeated START, each check that rejected data never reaches the array. Both cases are followed by a read of the same address.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  // Strobes from the bus control to the storage datapath
  typedef struct packed {
    logic       loadHi;     // address high byte received
    logic       loadLo;     // address low byte received
    logic       latchByte;  // data byte accepted into the page latch
    logic       incAddr;    // read byte handed to the shifter
    logic       discard;    // drop latched data
    logic       commit;     // STOP seen: copy the latch into the array
    logic [7:0] data;       // last received byte
  } strobe_t;
endpackage

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter logic [6:0] SEL_CODE = 7'b1010000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       wcIn,
  input  logic       busy,
  input  logic [7:0] rdData,
  output strobe_t    str,
  output logic       sdaLow
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AH, S_AL, S_WD, S_RD, S_WAIT} state_t;

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  state_t     state, nextSt, dest;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic [6:0] txReg;
  logic       inAck, mAck, ackByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11; sdaSync <= 2'b11;
      sclPrev <= 1'b1;  sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  logic sclNow, sdaNow, startDet, stopDet, sclRise, sclFall, isRx, rxDone, loadTx;
  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign isRx     = (state == S_DEV) || (state == S_AH) || (state == S_AL) || (state == S_WD);
  assign rxDone   = isRx & sclFall & ~inAck & (bitCnt == 4'd8);
  assign loadTx   = sclFall & inAck &
                    (((state != S_RD) & (nextSt == S_RD)) | ((state == S_RD) & mAck));

  // Acknowledge decision and destination for a completed received byte
  always_comb begin
    ackByte = 1'b0;
    dest    = S_WAIT;
    case (state)
      S_DEV: begin
        ackByte = (shiftReg[7:1] == SEL_CODE) & ~busy;
        dest    = shiftReg[0] ? S_RD : S_AH;
      end
      S_AH: begin ackByte = 1'b1; dest = S_AL; end
      S_AL: begin ackByte = 1'b1; dest = S_WD; end
      S_WD: begin ackByte = ~wcIn; dest = S_WD; end
      default: ;
    endcase
  end

  always_comb begin
    str           = '0;
    str.data      = shiftReg;
    str.loadHi    = rxDone & (state == S_AH);
    str.loadLo    = rxDone & (state == S_AL);
    str.latchByte = rxDone & (state == S_WD) & ~wcIn;
    str.discard   = startDet | (rxDone & (state == S_WD) & wcIn);
    str.commit    = stopDet;
    str.incAddr   = loadTx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; nextSt <= S_IDLE; bitCnt <= '0; shiftReg <= '0;
      txReg <= '0; inAck <= 1'b0; mAck <= 1'b0; sdaLow <= 1'b0;
    end else if (startDet) begin
      state <= S_DEV; bitCnt <= '0; inAck <= 1'b0; sdaLow <= 1'b0;
    end else if (stopDet) begin
      state <= S_IDLE; inAck <= 1'b0; sdaLow <= 1'b0;
    end else if (isRx) begin
      if (sclRise && !inAck && bitCnt < 4'd8) begin
        shiftReg <= {shiftReg[6:0], sdaNow};
        bitCnt   <= bitCnt + 4'd1;
      end
      if (rxDone) begin
        inAck  <= 1'b1;
        bitCnt <= '0;
        sdaLow <= ackByte;
        nextSt <= ackByte ? dest : S_WAIT;
      end else if (sclFall && inAck) begin
        inAck  <= 1'b0;
        state  <= nextSt;
        sdaLow <= loadTx ? ~rdData[7] : 1'b0;
        if (loadTx) txReg <= rdData[6:0];
      end
    end else if (state == S_RD) begin
      if (!inAck && sclFall) begin
        if (bitCnt == 4'd7) begin
          inAck <= 1'b1; sdaLow <= 1'b0; bitCnt <= '0;
        end else begin
          sdaLow <= ~txReg[6];
          txReg  <= {txReg[5:0], 1'b0};
          bitCnt <= bitCnt + 4'd1;
        end
      end
      if (inAck && sclRise) mAck <= ~sdaNow;
      if (inAck && sclFall) begin
        inAck <= 1'b0;
        if (mAck) begin
          txReg  <= rdData[6:0];
          sdaLow <= ~rdData[7];
        end else begin
          state  <= S_WAIT;
          sdaLow <= 1'b0;
        end
      end
    end
  end

  AST_FOREIGN_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && state == S_DEV && shiftReg[7:1] != SEL_CODE) |=> !sdaLow); // R1
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && state == S_DEV && busy) |=> !sdaLow); // R5
  AST_WC_DATA_NACK: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && state == S_WD && wcIn) |=> !sdaLow); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> !sdaLow); // R9
endmodule

// File: rtl/i2cee_datapath.sv
module i2cee_datapath
  import i2cee_pkg::*;
#(
  parameter int MEM_AW       = 9,
  parameter int PAGE_AW      = 6,
  parameter int WRITE_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    str,
  output logic [7:0] rdData,
  output logic       busy
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PAGE  = 1 << PAGE_AW;
  localparam int HI_W  = MEM_AW - 8;
  localparam int CW    = $clog2(WRITE_CYCLES + 1);
  localparam logic [PAGE_AW-1:0] OFF_ONE  = 1;
  localparam logic [MEM_AW-1:0]  ADDR_ONE = 1;
  localparam logic [CW-1:0]      CNT_ONE  = 1;

  logic [7:0]            mem [DEPTH];
  logic [7:0]            pageLatch [PAGE];
  logic [PAGE-1:0]       validMask;
  logic                  pending;
  logic [HI_W-1:0]       addrHi;
  logic [MEM_AW-1:0]     addr;
  logic [CW-1:0]         busyCnt;
  logic [MEM_AW-PAGE_AW-1:0] pageBase;
  logic [PAGE_AW-1:0]    nextOff;
  logic                  doCommit;

  assign busy     = (busyCnt != '0);
  assign rdData   = mem[addr];
  assign pageBase = addr[MEM_AW-1:PAGE_AW];
  assign nextOff  = addr[PAGE_AW-1:0] + OFF_ONE;
  assign doCommit = str.commit & pending & ~busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrHi <= '0; addr <= '0; validMask <= '0; pending <= 1'b0; busyCnt <= '0;
    end else begin
      if (str.loadHi)    addrHi <= str.data[HI_W-1:0];
      if (str.loadLo)    addr   <= {addrHi, str.data};
      if (str.latchByte) addr   <= {pageBase, nextOff};
      if (str.incAddr)   addr   <= addr + ADDR_ONE;
      if (str.commit || str.discard) begin
        validMask <= '0; pending <= 1'b0;
      end else if (str.latchByte) begin
        validMask[addr[PAGE_AW-1:0]] <= 1'b1;
        pending <= 1'b1;
      end
      if (doCommit)  busyCnt <= CW'(WRITE_CYCLES);
      else if (busy) busyCnt <= busyCnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (str.latchByte) pageLatch[addr[PAGE_AW-1:0]] <= str.data;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (doCommit) begin
      for (int i = 0; i < PAGE; i++)
        if (validMask[i]) mem[{pageBase, PAGE_AW'(i)}] <= pageLatch[i];
    end
  end

  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(str.commit)); // R4
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    str.latchByte |=> (addr[MEM_AW-1:PAGE_AW] == $past(addr[MEM_AW-1:PAGE_AW]))); // R6
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2cee_pkg::*;
#(
  parameter logic [6:0] SEL_CODE     = 7'b1010000,
  parameter int         MEM_AW       = 9,
  parameter int         PAGE_AW      = 6,
  parameter int         WRITE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wcIn,
  output logic sdaDriveLow
);
  strobe_t    str;
  logic [7:0] rdData;
  logic       busy;

  i2cee_ctrl #(.SEL_CODE(SEL_CODE)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .wcIn(wcIn),
    .busy(busy), .rdData(rdData), .str(str), .sdaLow(sdaDriveLow)
  );

  i2cee_datapath #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW), .WRITE_CYCLES(WRITE_CYCLES)) dp_i (
    .clk(clk), .rstN(rstN), .str(str), .rdData(rdData), .busy(busy)
  );
endmodule

// File: tb/i2c_eeprom_target_tb_top.sv
module i2c_eeprom_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WCYC       = 2000;
  localparam int DEPTH      = 512;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, sdaM = 1'b1, wc = 1'b0;
  logic dutLow, sdaLine;
  assign sdaLine = sdaM & ~dutLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_eeprom_target #(.SEL_CODE(7'b1010000), .MEM_AW(9), .PAGE_AW(6), .WRITE_CYCLES(WCYC)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .wcIn(wc), .sdaDriveLow(dutLow)
  );

  int nChecks = 0, nFail = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); ack = ~sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclM = 1'b1; waitQ(); b[i] = sdaLine; waitQ(); sclM = 1'b0;
    end
    waitQ(); sdaM = ~ackIt; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    sdaM = 1'b1;
  endtask

  task automatic doWrite(input int addr, input int n, output bit ok);
    bit a;
    ok = 1'b1;
    startC();
    sendByte(8'hA0, a); ok &= a;
    sendByte(8'(addr >> 8), a); ok &= a;
    sendByte(8'(addr), a); ok &= a;
    for (int i = 0; i < n; i++) begin sendByte(wbuf[i], a); ok &= a; end
    stopC();
    if (ok)
      for (int i = 0; i < n; i++) model[(addr & ~63) | ((addr + i) & 63)] = wbuf[i];
  endtask

  task automatic doRead(input int addr, input int n, output bit ok);
    bit a;
    logic [7:0] b;
    ok = 1'b1;
    startC();
    sendByte(8'hA0, a); ok &= a;
    sendByte(8'(addr >> 8), a); ok &= a;
    sendByte(8'(addr), a); ok &= a;
    startC();
    sendByte(8'hA1, a); ok &= a;
    for (int i = 0; i < n; i++) begin recvByte(i != n - 1, b); rbuf[i] = b; end
    stopC();
  endtask

  task automatic waitWrite();
    repeat (WCYC + 100) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    bit ok, a, a1, a2, a3, a4;
    logic [7:0] b;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    check(dutLow == 1'b0, "R10 reset release", int'(dutLow), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R10 and R7: erased array after reset
    doRead(0, 4, ok);
    check(ok, "R7 random read acks", int'(ok), 1);
    for (int i = 0; i < 4; i++) check(rbuf[i] == 8'hFF, "R10 erased byte", int'(rbuf[i]), 8'hFF);

    // R1: foreign select codes
    startC(); sendByte(8'hA2, a); sendByte(8'h00, a1); stopC();
    check(!a, "R1 foreign write select", int'(a), 0);
    check(!a1, "R1 later byte ignored", int'(a1), 0);
    startC(); sendByte(8'hB1, a); stopC();
    check(!a, "R1 foreign read select", int'(a), 0);

    // R2 and R5: two-byte write, then polling
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    doWrite(12'h012, 2, ok);
    check(ok, "R2 write acks", int'(ok), 1);
    startC(); sendByte(8'hA0, a); stopC();
    check(!a, "R5 write select while busy", int'(a), 0);
    startC(); sendByte(8'hA1, a); stopC();
    check(!a, "R5 read select while busy", int'(a), 0);
    waitWrite();
    startC(); sendByte(8'hA0, a); stopC();
    check(a, "R5 select after cycle", int'(a), 1);
    doRead(12'h012, 1, ok);
    check(rbuf[0] == model[12'h012], "R2 byte readable", int'(rbuf[0]), int'(model[12'h012]));
    startC(); sendByte(8'hA1, a); recvByte(1'b0, b); stopC();
    check(a && b == model[12'h013], "R8 current address read", int'(b), int'(model[12'h013]));

    // R6: page write that wraps inside page 2
    for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h30 + i * 7);
    doWrite(12'h0BC, 8, ok);
    check(ok, "R6 page write acks", int'(ok), 1);
    waitWrite();
    doRead(12'h080, 64, ok);
    for (int i = 0; i < 64; i++)
      check(rbuf[i] == model[12'h080 + i], "R6 page content", int'(rbuf[i]), int'(model[12'h080 + i]));
    check(model[12'h080] == 8'h30 + 8'd28, "R6 wrapped offset in model", int'(model[12'h080]), 8'h4C);

    // R3: write control blocks data
    wc = 1'b1;
    startC(); sendByte(8'hA0, a1); sendByte(8'h00, a2); sendByte(8'h30, a3); sendByte(8'h77, a4); stopC();
    wc = 1'b0;
    check(a1 && a2 && a3, "R3 select and address acked", int'({a1, a2, a3}), 7);
    check(!a4, "R3 data nacked", int'(a4), 0);
    startC(); sendByte(8'hA0, a); stopC();
    check(a, "R3 no write cycle", int'(a), 1);
    doRead(12'h030, 1, ok);
    check(rbuf[0] == 8'hFF, "R3 array unchanged", int'(rbuf[0]), 8'hFF);

    // R4: repeated START discards latched data
    startC(); sendByte(8'hA0, a1); sendByte(8'h00, a2); sendByte(8'h40, a3); sendByte(8'h11, a4);
    startC(); sendByte(8'hA1, a); recvByte(1'b0, b); stopC();
    check(a1 && a2 && a3 && a4 && a, "R4 transaction acks", int'({a1, a2, a3, a4, a}), 31);
    check(b == model[12'h041], "R4 read after discard", int'(b), int'(model[12'h041]));
    startC(); sendByte(8'hA0, a); stopC();
    check(a, "R4 no cycle after discard", int'(a), 1);
    doRead(12'h040, 1, ok);
    check(rbuf[0] == 8'hFF, "R4 discarded byte absent", int'(rbuf[0]), 8'hFF);

    // R9: sequential read across the top of the array
    wbuf[0] = 8'h3C; doWrite(12'h1FF, 1, ok); waitWrite();
    wbuf[0] = 8'hC3; doWrite(12'h000, 1, ok); waitWrite();
    doRead(12'h1FE, 4, ok);
    for (int i = 0; i < 4; i++)
      check(rbuf[i] == model[(12'h1FE + i) % DEPTH], "R9 sequential wrap", int'(rbuf[i]),
            int'(model[(12'h1FE + i) % DEPTH]));
    repeat (4) @(negedge clk);
    check(dutLow == 1'b0, "R9 line released after read", int'(dutLow), 0);

    finishRun();
  end
endmodule